// File: doc/BRIEF.md
# Serial Command Frame Receiver with Chained Output

This block is the serial front end of a small programmable device. An external host drives a four-wire serial link: chip select active low, serial clock, data in and data out. The block samples every bit in the local system clock domain and keeps the most recent 24 bits in a shift register. When chip select is released after a whole number of 24-bit words, the block emits a one-cycle strobe. The strobe carries the command, address and data fields of the last word received.

While a frame is being clocked in, the data output carries the bits that the shift register held before, so several devices can be chained output to input. After a read command, the next frame carries a value supplied by the register file in place of the chained bits. A busy input from the nonvolatile store controller freezes the receiver, and frames sent during that time have no effect.

The open-drain output stage is modelled as a data bit plus an output enable.

Top module: `spi_frame_port`

## Requirements
- R1: A frame is shifted in most significant bit first. When a command is issued, `cmd_op` equals bits 23..20, `cmd_addr` equals bits 19..16 and `cmd_data` equals bits 15..0 of the last 24 bits received. These fields hold their values until the next issued command.
- R2: A command is issued only when chip select rises, and only if the number of serial clock rising edges in that frame is a nonzero multiple of 24. Frames of 23 or 25 bits issue nothing.
- R3: Each accepted frame raises `cmd_valid` for exactly one system clock cycle.
- R4: Data in is sampled on serial clock rising edges. Data out changes on serial clock falling edges, and its first bit appears after chip select falls. Data out carries the previous contents of the 24-bit register, oldest bit first. In a 48-bit frame, the second 24 bits on data out equal the first 24 bits sent.
- R5: `spi_sdo_oe` is low whenever `spi_csn` is high, and high during a frame.
- R6: After an issued command with op 4'h9 or 4'hA, the next accepted frame shifts out {op, addr of that read, `rd_value`}. `rd_value` is sampled when that frame's chip select falls. The frame after that returns to chained data.
- R7: If `busy` is high when chip select falls, that frame issues no command and leaves the shift register unchanged. The next frame's data out shows the contents from before the busy frame.
- R8: If `busy` is high when chip select rises, no command is issued, even though the frame began while the block was not busy.
- R9: After reset, `cmd_valid`, `spi_sdo_oe` and all command fields are zero, and the first frame shifts out 24 zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_csn | input | 1 | Chip select, active low, asynchronous to clk |
| spi_sclk | input | 1 | Serial clock, asynchronous to clk |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out (chained or readback) |
| spi_sdo_oe | output | 1 | Drive enable for data out |
| busy | input | 1 | Store in progress; locks the receiver |
| rd_value | input | 16 | Register value returned for the frame after a read command |
| cmd_valid | output | 1 | One-cycle strobe for an accepted frame |
| cmd_op | output | 4 | Command field of the accepted frame |
| cmd_addr | output | 4 | Address field of the accepted frame |
| cmd_data | output | 16 | Data field of the accepted frame |

## Verification
Two events can meet in the same system cycle.

The first pair is the end of a frame and the busy lock. The bench clocks in a complete, valid 24-bit frame, then raises `busy` before it releases chip select. The busy level is therefore present in the very cycle that the synchronized rising edge of chip select is detected. The frame counts as correct if no strobe appears and the fields keep their old values.

The second pair is the start of a frame and the loading of readback data. The bench checks that the register value and the retained read header come out together as the first word of the following frame. A frame that is already locked when it starts is also exercised, and the bench confirms that its chained output history survives it.

// File: rtl/spf_pkg.sv
package spf_pkg;
    localparam int OP_W    = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 16;
    localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int HDR_W   = OP_W + ADDR_W;

    localparam logic [OP_W-1:0] OP_READ_STORE = 4'h9;
    localparam logic [OP_W-1:0] OP_READ_WIPER = 4'hA;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic wants_readback(input logic [OP_W-1:0] op);
        return (op == OP_READ_STORE) || (op == OP_READ_WIPER);
    endfunction
endpackage

// File: rtl/spf_sync.sv
module spf_sync #(
    parameter int         N      = 3,
    parameter int         STAGES = 2,
    parameter logic [N-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] q_sync
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{INIT[b]}};
            else     chain <= {chain[STAGES-2:0], d_async[b]};
        end
        assign q_sync[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/spf_edges.sv
module spf_edges (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic csn_s,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic frame_start,
    output logic frame_end
);
    logic sclk_d, csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    assign sclk_rise   =  sclk_s & ~sclk_d & ~csn_s;
    assign sclk_fall   = ~sclk_s &  sclk_d & ~csn_s;
    assign frame_start = ~csn_s &  csn_d;
    assign frame_end   =  csn_s & ~csn_d;
endmodule

// File: rtl/spf_shifter.sv
module spf_shifter
    import spf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              busy,
    input  logic              rb_pending,
    input  logic [DATA_W-1:0] rd_value,
    output logic [FRAME_W-1:0] sr,
    output logic              frame_ok,
    output logic              rb_taken,
    output logic              sdo_q,
    output logic              in_frame
);
    logic [CNT_W-1:0] cnt;
    logic             full;
    logic             locked;

    assign rb_taken = frame_start & ~busy & rb_pending;
    assign frame_ok = ~locked & full & (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr       <= '0;
            cnt      <= '0;
            full     <= 1'b0;
            locked   <= 1'b0;
            sdo_q    <= 1'b0;
            in_frame <= 1'b0;
        end else if (frame_start) begin
            locked   <= busy;
            cnt      <= '0;
            full     <= 1'b0;
            in_frame <= 1'b1;
            sdo_q    <= sr[FRAME_W-1];
            if (rb_taken) sr <= {sr[FRAME_W-1:DATA_W], rd_value};
        end else if (frame_end) begin
            in_frame <= 1'b0;
        end else if (in_frame && !locked) begin
            if (sclk_rise) begin
                sr <= {sr[FRAME_W-2:0], sdi_s};
                if (cnt == CNT_W'(FRAME_W - 1)) begin
                    cnt  <= '0;
                    full <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (sclk_fall) sdo_q <= sr[FRAME_W-1];
        end
    end

    // R7
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && in_frame && !frame_start) |=> $stable(sr));

    // R4
    sdo_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!sclk_fall && !frame_start) |=> $stable(sdo_q));
endmodule

// File: rtl/spf_issue.sv
module spf_issue
    import spf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_end,
    input  logic               frame_ok,
    input  logic               busy,
    input  logic               rb_taken,
    input  logic [FRAME_W-1:0] sr,
    output logic               cmd_valid,
    output frame_t             cmd,
    output logic               rb_pending
);
    frame_t incoming;
    logic   accept;

    assign incoming = frame_t'(sr);
    assign accept   = frame_end & frame_ok & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid  <= 1'b0;
            cmd        <= '0;
            rb_pending <= 1'b0;
        end else begin
            cmd_valid <= accept;
            if (rb_taken) rb_pending <= 1'b0;
            if (accept) begin
                cmd <= incoming;
                if (wants_readback(incoming.op)) rb_pending <= 1'b1;
            end
        end
    end

    // R3
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_valid) |-> !$past(busy));

    // R6
    readback_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && wants_readback(cmd.op)) |-> rb_pending);
endmodule

// File: rtl/spi_frame_port.sv
module spi_frame_port
    import spf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_value,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    logic [2:0]         raw_pins, sync_pins;
    logic               sclk_s, csn_s, sdi_s;
    logic               sclk_rise, sclk_fall, frame_start, frame_end;
    logic [FRAME_W-1:0] sr;
    logic               frame_ok, rb_taken, rb_pending, sdo_q, in_frame;
    frame_t             cmd;

    assign raw_pins = {spi_csn, spi_sclk, spi_sdi};
    assign {csn_s, sclk_s, sdi_s} = sync_pins;

    spf_sync #(.N(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
        .clk(clk), .rst(rst), .d_async(raw_pins), .q_sync(sync_pins)
    );

    spf_edges u_edges (
        .clk(clk), .rst(rst), .sclk_s(sclk_s), .csn_s(csn_s),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .frame_start(frame_start), .frame_end(frame_end)
    );

    spf_shifter u_shift (
        .clk(clk), .rst(rst), .sdi_s(sdi_s),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .frame_start(frame_start), .frame_end(frame_end),
        .busy(busy), .rb_pending(rb_pending), .rd_value(rd_value),
        .sr(sr), .frame_ok(frame_ok), .rb_taken(rb_taken),
        .sdo_q(sdo_q), .in_frame(in_frame)
    );

    spf_issue u_issue (
        .clk(clk), .rst(rst), .frame_end(frame_end), .frame_ok(frame_ok),
        .busy(busy), .rb_taken(rb_taken), .sr(sr),
        .cmd_valid(cmd_valid), .cmd(cmd), .rb_pending(rb_pending)
    );

    assign spi_sdo    = sdo_q;
    assign spi_sdo_oe = ~spi_csn & in_frame;
    assign cmd_op     = cmd.op;
    assign cmd_addr   = cmd.addr;
    assign cmd_data   = cmd.data;

    // R2
    issue_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_valid) |-> $past(frame_end));
endmodule

// File: tb/tb_spi_frame_port.sv
`timescale 1ns/1ps
module tb_spi_frame_port;
    localparam int HALF = 8;
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [NVEC] = '{
        24'h1A5C3F, 24'hB20123, 24'hE0FFFF, 24'h3D8001, 24'h000000, 24'h27AAAA
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_csn = 1'b1, spi_sclk = 1'b0, spi_sdi = 1'b0;
    logic        spi_sdo, spi_sdo_oe;
    logic        busy = 1'b0;
    logic [15:0] rd_value = 16'h0000;
    logic        cmd_valid;
    logic [3:0]  cmd_op, cmd_addr;
    logic [15:0] cmd_data;

    int errors = 0, checks = 0, strobes = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    spi_frame_port dut (
        .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .busy(busy), .rd_value(rd_value), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    always @(negedge clk) if (!rst && cmd_valid) strobes++;

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_begin();
        @(negedge clk); spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic put_bit(input logic b, output logic so);
        spi_sdi = b;
        repeat (HALF) @(negedge clk);
        so = spi_sdo;
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    task automatic cs_end();
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [47:0] v, input int n, output logic [47:0] so);
        so = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic b;
            put_bit(v[i], b);
            so[i] = b;
        end
    endtask

    task automatic send(input logic [47:0] v, input int n, output logic [47:0] so);
        cs_begin();
        shift_bits(v, n, so);
        cs_end();
    endtask

    // Checks the fields and the strobe count after one accepted frame (R1, R3)
    task automatic expect_cmd(input logic [23:0] f, input int s0, input string tag);
        chk(strobes == s0 + 1, {tag, " R3 one strobe"}, 48'(strobes - s0), 48'd1);
        chk({cmd_op, cmd_addr, cmd_data} == f, {tag, " R1 fields"},
            48'({cmd_op, cmd_addr, cmd_data}), 48'(f));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [47:0] so;
        logic [23:0] prev;
        int s0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R9 reset state
        chk(!cmd_valid && !spi_sdo_oe, "R9 strobe/oe", 48'({cmd_valid, spi_sdo_oe}), 48'd0);
        chk({cmd_op, cmd_addr, cmd_data} == 24'd0, "R9 fields", 48'({cmd_op, cmd_addr, cmd_data}), 48'd0);
        // R5 released while idle
        chk(!spi_sdo_oe, "R5 idle oe", 48'(spi_sdo_oe), 48'd0);

        // Table walk: each frame is decoded (R1) and the next frame echoes it (R4)
        prev = 24'h000000;
        for (int k = 0; k < NVEC; k++) begin
            s0 = strobes;
            cs_begin();
            if (k == 0) chk(spi_sdo_oe, "R5 oe in frame", 48'(spi_sdo_oe), 48'd1);
            shift_bits(48'(VEC[k]), 24, so);
            cs_end();
            if (k == 0) chk(so[23:0] == 24'd0, "R9 first frame zeros", so, 48'd0);
            else        chk(so[23:0] == prev, "R4 chained echo", so, 48'(prev));
            expect_cmd(VEC[k], s0, "table");
            prev = VEC[k];
        end

        // R2 short frame of 23 bits
        s0 = strobes;
        send(48'h0ABCDE, 23, so);
        chk(strobes == s0, "R2 23 bits", 48'(strobes - s0), 48'd0);
        chk({cmd_op, cmd_addr, cmd_data} == prev, "R2 fields kept", 48'({cmd_op, cmd_addr, cmd_data}), 48'(prev));
        // R2 long frame of 25 bits
        send(48'h1FEDCBA, 25, so);
        chk(strobes == s0, "R2 25 bits", 48'(strobes - s0), 48'd0);
        // R2 empty frame
        send(48'h0, 0, so);
        chk(strobes == s0, "R2 0 bits", 48'(strobes - s0), 48'd0);

        // R4 two chained words in one 48-bit frame
        s0 = strobes;
        send(48'hC1234D_E5678F, 48, so);
        chk(so[23:0] == 24'hC1234D, "R4 second word echoes first", so, 48'hC1234D);
        expect_cmd(24'hE5678F, s0, "R4 48-bit");

        // R6 readback: read command, then the next frame carries header and value
        rd_value = 16'hBEEF;
        s0 = strobes;
        send(48'h930000, 24, so);
        expect_cmd(24'h930000, s0, "R6 read cmd");
        s0 = strobes;
        send(48'h4C1111, 24, so);
        chk(so[23:0] == 24'h93BEEF, "R6 readback word", so, 48'h93BEEF);
        expect_cmd(24'h4C1111, s0, "R6 follow");
        send(48'h5D2222, 24, so);
        chk(so[23:0] == 24'h4C1111, "R6 back to chaining", so, 48'h4C1111);

        // R6 with the other read op
        rd_value = 16'h0F0F;
        send(48'hA50000, 24, so);
        send(48'h600000, 24, so);
        chk(so[23:0] == 24'hA50F0F, "R6 read op A", so, 48'hA50F0F);

        // R7 busy at frame start: dropped, register unchanged
        send(48'h7E3333, 24, so);
        busy = 1'b1;
        repeat (4) @(negedge clk);
        s0 = strobes;
        send(48'h8F4444, 24, so);
        busy = 1'b0;
        repeat (4) @(negedge clk);
        chk(strobes == s0, "R7 no strobe when locked", 48'(strobes - s0), 48'd0);
        chk({cmd_op, cmd_addr, cmd_data} == 24'h7E3333, "R7 fields kept",
            48'({cmd_op, cmd_addr, cmd_data}), 48'h7E3333);
        send(48'h125555, 24, so);
        chk(so[23:0] == 24'h7E3333, "R7 register unchanged", so, 48'h7E3333);

        // R8 busy rises before chip select is released
        s0 = strobes;
        cs_begin();
        shift_bits(48'h2B6666, 24, so);
        busy = 1'b1;
        cs_end();
        busy = 1'b0;
        repeat (4) @(negedge clk);
        chk(strobes == s0, "R8 no strobe", 48'(strobes - s0), 48'd0);
        chk({cmd_op, cmd_addr, cmd_data} == 24'h125555, "R8 fields kept",
            48'({cmd_op, cmd_addr, cmd_data}), 48'h125555);
        chk(!spi_sdo_oe, "R5 released after frame", 48'(spi_sdo_oe), 48'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule